// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block computes and registers the control-state changes that a 32-bit RISC core makes when it takes a reset, a general exception, a TLB-miss exception, a trap or an interrupt. Each cycle the core presents its current program counter, status word, vector base, stack pointer (R15), its separately held T, S, M and Q condition flags and its delay-slot flag. It also raises at most a handful of request lines together with an event code, a delay-slot variant of that code and a trap immediate.

On the clock edge that accepts a request, the block loads the new program counter and the following fetch address. Except on reset, it loads the saved PC, saved status and saved stack pointer. It also loads the new status word and whichever event registers the request writes. It emits one-cycle pulses that mark the entry and tell the register file to exchange its general-register banks. When no request is present, every saved value holds and the delay-slot output follows the core's flag.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, pc_o = 0xA0000000, npc_o = 0xA0000002, sr_o = 0x700000F0, fpscr_o = 0x00040001, and spc_o, ssr_o, sgr_o, expevt_o, intevt_o, tra_o, entry_o, bank_swap_o and ds_o are all zero.
- R2: On an accepted non-reset request, the edge that accepts it loads spc_o with cur_pc, ssr_o with the merged status word and sgr_o with cur_r15.
- R3: On a non-reset entry, sr_o becomes the merged status word with bit 30 (privileged), bit 29 (bank select) and bit 28 (block) forced to one.
- R4: bank_swap_o pulses for one cycle with the entry exactly when bits 30 and 29 of the merged status word were not both one.
- R5: An interrupt (req_int) loads intevt_o with evt_code and pc_o with cur_vbr + 0x600, and leaves expevt_o unchanged.
- R6: A general exception (req_exc) loads expevt_o with its code and pc_o with cur_vbr + 0x100. A TLB miss (req_tlb) does the same with cur_vbr + 0x400.
- R7: A trap (req_trap) loads tra_o with trap_imm shifted left by two, loads expevt_o with 0x160 and sets pc_o to cur_vbr + 0x100.
- R8: A reset request loads expevt_o with evt_code and pc_o with 0xA0000000 regardless of cur_vbr. It sets sr_o to the merged word with bits 30, 29 and 28 and the interrupt mask bits 7:4 all one, and leaves spc_o, ssr_o and sgr_o unchanged.
- R9: After any entry, npc_o = pc_o + 2 and ds_o = 0. In a cycle without a request, ds_o takes in_slot.
- R10: For req_exc and req_tlb with in_slot high, expevt_o takes slot_code instead of evt_code.
- R11: The merged status word is cur_sr with bits 0 (T), 1 (S), 8 (Q) and 9 (M) replaced by flag_t, flag_s, flag_q and flag_m.
- R12: Exactly one request is taken per cycle, with priority req_reset, req_exc, req_tlb, req_trap, req_int from highest to lowest. With no request, pc_o, npc_o, sr_o, spc_o, ssr_o, sgr_o and the event registers hold and entry_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_reset | input | 1 | Reset entry request |
| req_exc | input | 1 | General exception request |
| req_tlb | input | 1 | TLB-miss exception request |
| req_trap | input | 1 | Trap request |
| req_int | input | 1 | Accepted interrupt request |
| evt_code | input | 12 | Event code for reset, exception or interrupt |
| slot_code | input | 12 | Exception code used in a delay slot |
| trap_imm | input | 8 | Trap immediate |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| cur_vbr | input | 32 | Vector base |
| cur_r15 | input | 32 | Current stack pointer |
| flag_t | input | 1 | T flag |
| flag_s | input | 1 | S flag |
| flag_m | input | 1 | M flag |
| flag_q | input | 1 | Q flag |
| in_slot | input | 1 | Faulting instruction is in a delay slot |
| pc_o | output | 32 | New program counter |
| npc_o | output | 32 | Following fetch address |
| spc_o | output | 32 | Saved program counter |
| ssr_o | output | 32 | Saved status word |
| sgr_o | output | 32 | Saved stack pointer |
| sr_o | output | 32 | New status word |
| fpscr_o | output | 32 | Floating-point control power-on value |
| expevt_o | output | 32 | Exception event register |
| intevt_o | output | 32 | Interrupt event register |
| tra_o | output | 32 | Trap value register |
| bank_swap_o | output | 1 | Exchange general-register banks (pulse) |
| entry_o | output | 1 | An entry was taken (pulse) |
| ds_o | output | 1 | Delay-slot flag |

## Verification
Every result of this block is due one edge after the request: the edge that sees the request loads the PC, saved state, status and event registers, and raises the entry and bank-swap pulses for the cycle that follows. The bench drives each request on a falling edge, lets one rising edge pass, and compares all outputs one time unit later. It then drops the request, so that each pulse is seen in the only cycle it is valid. An idle cycle between vectors also checks that values hold and that the delay-slot output follows its input.

// File: rtl/exc_pkg.sv
package exc_pkg;
   // request index, lowest index wins
   localparam int K_RESET  = 0;
   localparam int K_EXC    = 1;
   localparam int K_TLB    = 2;
   localparam int K_TRAP   = 3;
   localparam int K_INT    = 4;
   localparam int NUM_KIND = 5;

   // status word bit positions
   localparam int SR_MD_BIT = 30;
   localparam int SR_RB_BIT = 29;
   localparam int SR_BL_BIT = 28;
   localparam int SR_M_BIT  = 9;
   localparam int SR_Q_BIT  = 8;
   localparam int SR_S_BIT  = 1;
   localparam int SR_T_BIT  = 0;
   localparam int SR_IM_LO  = 4;
   localparam int SR_IM_W   = 4;
endpackage

// File: rtl/exc_req_pick.sv
module exc_req_pick #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   generate
      if (N < 2) begin : g_bad
         $error("exc_req_pick needs at least two requesters");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_pri
         if (i == 0) begin : g_top
            assign grant[i] = req[i];
         end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

   assign any = |req;

   // R12: never more than one grant, and a grant whenever a request exists
   a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/exc_sr_merge.sv
module exc_sr_merge
   import exc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] cur_sr,
   input  logic            flag_t,
   input  logic            flag_s,
   input  logic            flag_m,
   input  logic            flag_q,
   input  logic            is_reset,
   output logic [XLEN-1:0] merged_sr,
   output logic [XLEN-1:0] new_sr,
   output logic            swap
);
   localparam logic [XLEN-1:0] FLAG_MASK = XLEN'((1 << SR_T_BIT) | (1 << SR_S_BIT) |
                                                 (1 << SR_Q_BIT) | (1 << SR_M_BIT));
   localparam logic [XLEN-1:0] ENTRY_SET = XLEN'((1 << SR_MD_BIT) | (1 << SR_RB_BIT) |
                                                 (1 << SR_BL_BIT));
   localparam logic [XLEN-1:0] IMASK_SET = XLEN'(((1 << SR_IM_W) - 1) << SR_IM_LO);

   logic [XLEN-1:0] flag_bits;
   logic            old_bank, new_bank;

   always_comb begin
      flag_bits = '0;
      flag_bits[SR_T_BIT] = flag_t;
      flag_bits[SR_S_BIT] = flag_s;
      flag_bits[SR_M_BIT] = flag_m;
      flag_bits[SR_Q_BIT] = flag_q;
      merged_sr = (cur_sr & ~FLAG_MASK) | flag_bits;
      new_sr    = merged_sr | ENTRY_SET | (is_reset ? IMASK_SET : '0);
   end

   assign old_bank = merged_sr[SR_MD_BIT] & merged_sr[SR_RB_BIT];
   assign new_bank = new_sr[SR_MD_BIT] & new_sr[SR_RB_BIT];
   assign swap     = old_bank ^ new_bank;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              CODE_W    = 12,
   parameter int              IMM_W     = 8,
   parameter logic [XLEN-1:0] RESET_PC  = 'hA000_0000,
   parameter logic [XLEN-1:0] OFF_EXC   = 'h100,
   parameter logic [XLEN-1:0] OFF_TLB   = 'h400,
   parameter logic [XLEN-1:0] OFF_INT   = 'h600,
   parameter logic [CODE_W-1:0] TRAP_CODE = 'h160
) (
   input  logic [NUM_KIND-1:0] grant,
   input  logic [XLEN-1:0]     vbr,
   input  logic [CODE_W-1:0]   code,
   input  logic [CODE_W-1:0]   slot_code,
   input  logic                in_slot,
   input  logic [IMM_W-1:0]    imm,
   output logic [XLEN-1:0]     new_pc,
   output logic                exp_we,
   output logic [XLEN-1:0]     exp_val,
   output logic                int_we,
   output logic [XLEN-1:0]     int_val,
   output logic                tra_we,
   output logic [XLEN-1:0]     tra_val
);
   localparam int PAD_C = XLEN - CODE_W;
   localparam int PAD_T = XLEN - IMM_W - 2;

   generate
      if (PAD_C < 0 || PAD_T < 0) begin : g_bad
         $error("exc_vector_gen: codes or immediate too wide for XLEN");
      end
   endgenerate

   logic [CODE_W-1:0] fault_code;
   assign fault_code = in_slot ? slot_code : code;
   assign int_val    = {{PAD_C{1'b0}}, code};
   assign tra_val    = {{PAD_T{1'b0}}, imm, 2'b00};

   always_comb begin
      new_pc  = vbr + OFF_EXC;
      exp_we  = 1'b0;
      exp_val = {{PAD_C{1'b0}}, code};
      int_we  = 1'b0;
      tra_we  = 1'b0;
      if (grant[K_RESET]) begin
         new_pc = RESET_PC;
         exp_we = 1'b1;
      end else if (grant[K_EXC]) begin
         exp_we  = 1'b1;
         exp_val = {{PAD_C{1'b0}}, fault_code};
      end else if (grant[K_TLB]) begin
         new_pc  = vbr + OFF_TLB;
         exp_we  = 1'b1;
         exp_val = {{PAD_C{1'b0}}, fault_code};
      end else if (grant[K_TRAP]) begin
         exp_we  = 1'b1;
         exp_val = {{PAD_C{1'b0}}, TRAP_CODE};
         tra_we  = 1'b1;
      end else if (grant[K_INT]) begin
         new_pc = vbr + OFF_INT;
         int_we = 1'b1;
      end
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              CODE_W     = 12,
   parameter int              IMM_W      = 8,
   parameter logic [XLEN-1:0] RESET_PC   = 'hA000_0000,
   parameter logic [XLEN-1:0] SR_INIT    = 'h7000_00F0,
   parameter logic [XLEN-1:0] FPSCR_INIT = 'h0004_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_reset,
   input  logic              req_exc,
   input  logic              req_tlb,
   input  logic              req_trap,
   input  logic              req_int,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [CODE_W-1:0] slot_code,
   input  logic [IMM_W-1:0]  trap_imm,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   cur_sr,
   input  logic [XLEN-1:0]   cur_vbr,
   input  logic [XLEN-1:0]   cur_r15,
   input  logic              flag_t,
   input  logic              flag_s,
   input  logic              flag_m,
   input  logic              flag_q,
   input  logic              in_slot,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   npc_o,
   output logic [XLEN-1:0]   spc_o,
   output logic [XLEN-1:0]   ssr_o,
   output logic [XLEN-1:0]   sgr_o,
   output logic [XLEN-1:0]   sr_o,
   output logic [XLEN-1:0]   fpscr_o,
   output logic [XLEN-1:0]   expevt_o,
   output logic [XLEN-1:0]   intevt_o,
   output logic [XLEN-1:0]   tra_o,
   output logic              bank_swap_o,
   output logic              entry_o,
   output logic              ds_o
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_entry_unit: XLEN must be at least 32");
      end
   endgenerate

   logic [NUM_KIND-1:0] req, grant;
   logic                any_req;
   logic [XLEN-1:0]     merged_sr, new_sr, new_pc;
   logic [XLEN-1:0]     exp_val, int_val, tra_val;
   logic                swap, exp_we, int_we, tra_we;

   always_comb begin
      req          = '0;
      req[K_RESET] = req_reset;
      req[K_EXC]   = req_exc;
      req[K_TLB]   = req_tlb;
      req[K_TRAP]  = req_trap;
      req[K_INT]   = req_int;
   end

   exc_req_pick #(.N(NUM_KIND)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any(any_req));

   exc_sr_merge #(.XLEN(XLEN)) u_merge (
      .cur_sr(cur_sr), .flag_t(flag_t), .flag_s(flag_s), .flag_m(flag_m),
      .flag_q(flag_q), .is_reset(grant[K_RESET]), .merged_sr(merged_sr),
      .new_sr(new_sr), .swap(swap));

   exc_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .IMM_W(IMM_W),
                    .RESET_PC(RESET_PC)) u_vec (
      .grant(grant), .vbr(cur_vbr), .code(evt_code), .slot_code(slot_code),
      .in_slot(in_slot), .imm(trap_imm), .new_pc(new_pc), .exp_we(exp_we),
      .exp_val(exp_val), .int_we(int_we), .int_val(int_val), .tra_we(tra_we),
      .tra_val(tra_val));

   assign fpscr_o = FPSCR_INIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o        <= RESET_PC;
         npc_o       <= RESET_PC + XLEN'(2);
         sr_o        <= SR_INIT;
         spc_o       <= '0;
         ssr_o       <= '0;
         sgr_o       <= '0;
         expevt_o    <= '0;
         intevt_o    <= '0;
         tra_o       <= '0;
         bank_swap_o <= 1'b0;
         entry_o     <= 1'b0;
         ds_o        <= 1'b0;
      end else begin
         entry_o     <= any_req;
         bank_swap_o <= any_req & swap;
         ds_o        <= any_req ? 1'b0 : in_slot;
         if (any_req) begin
            pc_o  <= new_pc;
            npc_o <= new_pc + XLEN'(2);
            sr_o  <= new_sr;
            if (!grant[K_RESET]) begin
               spc_o <= cur_pc;
               ssr_o <= merged_sr;
               sgr_o <= cur_r15;
            end
         end
         if (exp_we) expevt_o <= exp_val;
         if (int_we) intevt_o <= int_val;
         if (tra_we) tra_o    <= tra_val;
      end
   end

   // R2: saved state captured from the core on non-reset entry
   a_r2_save: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && !req_reset) |=> (spc_o == $past(cur_pc)) && (sgr_o == $past(cur_r15)));
   // R3: entry always leaves privileged, blocked, bank-1 state
   a_r3_sr_forced: assert property (@(posedge clk) disable iff (!rst_n)
      entry_o |-> (sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT]));
   // R8: reset entry goes to the fixed vector with full mask
   a_r8_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> (pc_o == RESET_PC) && (sr_o[SR_IM_LO +: SR_IM_W] == '1));
   // R9: fetch address follows and delay-slot flag is cleared
   a_r9_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      entry_o |-> (npc_o == pc_o + XLEN'(2)) && !ds_o);
   // R12: nothing moves without a request
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_reset || req_exc || req_tlb || req_trap || req_int) |=>
         $stable(pc_o) && $stable(sr_o) && $stable(spc_o) && !entry_o);
endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_reset = 0, req_exc = 0, req_tlb = 0, req_trap = 0, req_int = 0;
   logic [11:0] evt_code = '0, slot_code = '0;
   logic [7:0]  trap_imm = '0;
   logic [31:0] cur_pc = '0, cur_sr = '0, cur_vbr = '0, cur_r15 = '0;
   logic        flag_t = 0, flag_s = 0, flag_m = 0, flag_q = 0, in_slot = 0;
   logic [31:0] pc_o, npc_o, spc_o, ssr_o, sgr_o, sr_o, fpscr_o, expevt_o, intevt_o, tra_o;
   logic        bank_swap_o, entry_o, ds_o;

   always #4 clk = ~clk;

   exc_entry_unit i_exc_entry_unit (.*);

   typedef struct packed {
      logic [4:0]  req;      // {reset, exc, tlb, trap, int}
      logic [11:0] code;
      logic [11:0] slot;
      logic [7:0]  imm;
      logic [31:0] pc;
      logic [31:0] sr;
      logic [31:0] vbr;
      logic [31:0] r15;
      logic [3:0]  flags;    // {t, s, m, q}
      logic        ds;
      logic [31:0] exp_pc;
      logic [31:0] exp_sr;
   } vec_t;

   localparam int NV = 9;
   localparam logic [233:0] TBL [NV] = '{
      {5'b01000, 12'h0E0, 12'h1A0, 8'h00, 32'h8C001000, 32'h00000000, 32'h8C000000, 32'h8CFF0000, 4'b1000, 1'b0, 32'h8C000100, 32'h70000001},
      {5'b01000, 12'h0E0, 12'h1A0, 8'h00, 32'h8C002000, 32'h400000F0, 32'h8C000000, 32'h8CFF0010, 4'b0101, 1'b1, 32'h8C000100, 32'h700001F2},
      {5'b00100, 12'h040, 12'h1A0, 8'h00, 32'h00003000, 32'h60000000, 32'h00001000, 32'h00000100, 4'b0010, 1'b0, 32'h00001400, 32'h70000200},
      {5'b00010, 12'h000, 12'h000, 8'h3F, 32'h8C004000, 32'h70000000, 32'h8C010000, 32'h12345678, 4'b0000, 1'b0, 32'h8C010100, 32'h70000000},
      {5'b00001, 12'h320, 12'h000, 8'h00, 32'h8C005000, 32'h000000F0, 32'h8C000000, 32'h0000ABCD, 4'b0000, 1'b0, 32'h8C000600, 32'h700000F0},
      {5'b10000, 12'h020, 12'h000, 8'h00, 32'h8C006000, 32'h00000000, 32'h12345678, 32'h11111111, 4'b1000, 1'b0, 32'hA0000000, 32'h700000F1},
      {5'b11111, 12'h000, 12'h1A0, 8'hAA, 32'h8C007000, 32'h40000000, 32'h8C000000, 32'h22222222, 4'b0000, 1'b1, 32'hA0000000, 32'h700000F0},
      {5'b01001, 12'h100, 12'h1A0, 8'h00, 32'h8C008000, 32'h00000303, 32'h8C000000, 32'h44444444, 4'b0000, 1'b0, 32'h8C000100, 32'h70000000},
      {5'b00110, 12'h1C0, 12'h820, 8'h11, 32'h8C009000, 32'h30000000, 32'h00000000, 32'h33333333, 4'b0000, 1'b1, 32'h00000400, 32'h70000000}
   };

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bench model of saved / event state
   logic [31:0] m_spc = 0, m_ssr = 0, m_sgr = 0, m_exp = 0, m_int = 0, m_tra = 0;

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pc", pc_o, 32'hA0000000);
      chk("R1 npc", npc_o, 32'hA0000002);
      chk("R1 sr", sr_o, 32'h700000F0);
      chk("R1 fpscr", fpscr_o, 32'h00040001);
      chk("R1 saved", spc_o | ssr_o | sgr_o, 32'h0);
      chk("R1 events", expevt_o | intevt_o | tra_o, 32'h0);
      chk("R1 pulses", {29'd0, entry_o, bank_swap_o, ds_o}, 32'h0);
      rst_n = 1'b1;

      // R12 / R9: idle cycle holds, delay-slot output follows input
      @(negedge clk);
      cur_pc = 32'h1234; cur_sr = 32'hFFFF; cur_vbr = 32'h5000; in_slot = 1'b1;
      @(posedge clk); #1;
      chk("R12 idle pc hold", pc_o, 32'hA0000000);
      chk("R12 idle sr hold", sr_o, 32'h700000F0);
      chk("R12 idle no entry", {31'd0, entry_o}, 32'h0);
      chk("R9 idle ds follows", {31'd0, ds_o}, 32'h1);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [31:0] merged;
         int kind;
         v = vec_t'(TBL[i]);
         @(negedge clk);
         {req_reset, req_exc, req_tlb, req_trap, req_int} = v.req;
         evt_code = v.code; slot_code = v.slot; trap_imm = v.imm;
         cur_pc = v.pc; cur_sr = v.sr; cur_vbr = v.vbr; cur_r15 = v.r15;
         {flag_t, flag_s, flag_m, flag_q} = v.flags; in_slot = v.ds;
         // R11: flag merge, R12: priority
         merged = (v.sr & ~32'h303) | {22'd0, v.flags[1], v.flags[0], 6'd0, v.flags[2], v.flags[3]};
         kind = v.req[4] ? 0 : v.req[3] ? 1 : v.req[2] ? 2 : v.req[1] ? 3 : 4;
         if (kind != 0) begin
            m_spc = v.pc; m_ssr = merged; m_sgr = v.r15;
         end
         case (kind)
            0: m_exp = {20'd0, v.code};
            1, 2: m_exp = {20'd0, v.ds ? v.slot : v.code};   // R10
            3: begin m_exp = 32'h160; m_tra = {22'd0, v.imm, 2'b00}; end
            default: m_int = {20'd0, v.code};
         endcase
         @(posedge clk); #1;
         chk("R5 R6 R7 R8 R12 pc", pc_o, v.exp_pc);
         chk("R3 R8 R11 sr", sr_o, v.exp_sr);
         chk("R2 spc", spc_o, m_spc);
         chk("R2 R11 ssr", ssr_o, m_ssr);
         chk("R2 sgr", sgr_o, m_sgr);
         chk("R6 R7 R8 R10 expevt", expevt_o, m_exp);
         chk("R5 intevt", intevt_o, m_int);
         chk("R7 tra", tra_o, m_tra);
         chk("R9 npc", npc_o, v.exp_pc + 32'd2);
         chk("R9 ds cleared", {31'd0, ds_o}, 32'h0);
         chk("R4 swap", {31'd0, bank_swap_o}, {31'd0, !(merged[30] && merged[29])});
         chk("R12 entry", {31'd0, entry_o}, 32'h1);
         @(negedge clk);
         {req_reset, req_exc, req_tlb, req_trap, req_int} = 5'b0;
         in_slot = 1'b0;
         @(posedge clk); #1;
         chk("R12 hold after entry", pc_o, v.exp_pc);
         chk("R4 swap one cycle", {30'd0, bank_swap_o, entry_o}, 32'h0);
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule